// File: doc/BRIEF.md
# Write-Protected RTC Register Controller

This block is the register front end of a real-time clock. A byte-oriented host port delivers a transfer as a two-byte register address (a header), followed by any number of data bytes to write or read; each byte moves an internal address pointer forward by one, so a single header serves a whole burst. The block holds the nonvolatile alarm and trim bytes and the volatile time bank, and it presents the status byte, which is built from live flags.

Writing is guarded. The host must first set a write-enable latch and then a register-write enable through the status register. Only with both set does a write to any other register land. When a transfer that wrote into the nonvolatile region ends, the block drops the register-write enable by itself and stays busy for a programmable number of clock cycles, ignoring every write. A clock-failure flag is raised by reset and is cleared when a transfer that wrote the time bank completes. The low three bits of the digital-trim register are decoded into a signed ppm correction.

Top module: `rtc_wp_ctrl`

## Requirements
- R1: After reset `clk_fail` is 1, `busy` is 0, every stored register reads 0x00, and with `alarm_in` low the status register (address 0x3F) reads 0x01.
- R2: The status byte is {2'b00, alarm, 2'b00, reg_write_enable, write_enable_latch, clock_fail}. Writing 0x02 sets the latch and clears the register enable, writing 0x06 sets the register enable only when the latch is already set, writing 0x00 clears both, and any other value is ignored. Bits 0 and 5 are never changed by a write.
- R3: A write to any address other than 0x3F changes nothing unless the latch and the register enable are both set.
- R4: A header with `addr_hi` = 0 loads the pointer from `addr_lo`. Each write or read byte then advances the pointer by one, so a burst reaches consecutive addresses.
- R5: A `stop` that ends a transfer with at least one accepted write below 0x30 clears the register enable, keeps the latch, and holds `busy` high for BUSY_CYCLES cycles.
- R6: While `busy` is high, every write is ignored, including writes to the status register.
- R7: Bits that are not implemented read as zero. These are status bits 7:6 and 4:3, all of register 0x10, bits 4:3 of 0x11, bits 7:6 of 0x12, bits 7:3 of 0x13, and every address that is not stored (0x14 to 0x2F, 0x38 to 0x3E, and above 0x3F).
- R8: A read byte returns data with `rd_ack` on the following cycle. A read changes nothing except the pointer.
- R9: A `stop` that ends a transfer with an accepted write in 0x30 to 0x37 clears `clk_fail` and status bit 0.
- R10: `trim_ppm` is a signed value taken from bits 2:0 of register 0x13. Bit 0 adds 20, bit 1 adds 10, and bit 2 negates the sum.
- R11: Status bit 5 shows the present level of `alarm_in`.
- R12: After a header with a nonzero `addr_hi`, writes are ignored and reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_vld | input | 1 | Header strobe that loads the pointer |
| addr_hi | input | 8 | High address byte; must be zero |
| addr_lo | input | 8 | Low address byte |
| wr_vld | input | 1 | Write one byte at the pointer |
| wr_byte | input | 8 | Write data |
| rd_vld | input | 1 | Read one byte at the pointer |
| stop | input | 1 | End of transfer |
| alarm_in | input | 1 | Alarm match level shown in status bit 5 |
| rd_data | output | 8 | Read data |
| rd_ack | output | 1 | Read data valid |
| busy | output | 1 | Nonvolatile write period in progress |
| clk_fail | output | 1 | Clock-failure flag |
| trim_ppm | output | 6 | Signed decoded digital trim |

## Verification
A wrong enable state shows up on the next status read. It also shows up one read later as data that landed in a locked register, or as data that failed to land after a correct unlock. A wrong pointer shows up as a burst read that returns the wrong byte in the wrong position, on the cycle after the read strobe. Errors in the busy timer or the relock appear on the `busy` output one cycle after `stop`, and as a status write during the busy window that takes effect when it should not. The reserved-bit masks are checked by writing all ones and reading the bytes back.

// File: rtl/rtc_wp_pkg.sv
package rtc_wp_pkg;

    localparam logic [7:0] STATUS_ADDR = 8'h3F;
    localparam logic [7:0] NV_LIMIT    = 8'h30;
    localparam logic [7:0] DTRIM_ADDR  = 8'h13;

    // Writable bits of each stored register; cleared bits read as zero.
    function automatic logic [7:0] keep_mask(input logic [7:0] a);
        case (a)
            8'h10:   keep_mask = 8'h00;
            8'h11:   keep_mask = 8'hE7;
            8'h12:   keep_mask = 8'h3F;
            8'h13:   keep_mask = 8'h07;
            default: keep_mask = 8'hFF;
        endcase
    endfunction

    function automatic logic signed [5:0] trim_decode(input logic [2:0] b);
        logic signed [5:0] m;
        m = 6'sd0;
        if (b[0]) m = m + 6'sd20;
        if (b[1]) m = m + 6'sd10;
        if (b[2]) m = -m;
        return m;
    endfunction

endpackage

// File: rtl/rtc_wp_regbank.sv
module rtc_wp_regbank
    import rtc_wp_pkg::*;
#(
    parameter int NV_DEPTH = 20,
    parameter int TB_BASE  = 48,
    parameter int TB_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr,
    output logic [7:0] rdata,
    output logic [2:0] dtrim_bits
);

    typedef struct packed {
        logic [NV_DEPTH-1:0][7:0] nv;
        logic [TB_DEPTH-1:0][7:0] tb;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d     = bank_q;
        rdata      = 8'h00;
        dtrim_bits = 3'b000;
        for (int i = 0; i < NV_DEPTH; i++) begin
            if (we && waddr == 8'(i))
                bank_d.nv[i] = wdata & keep_mask(waddr);
            if (raddr == 8'(i))
                rdata = bank_q.nv[i];
            if (DTRIM_ADDR == 8'(i))
                dtrim_bits = bank_q.nv[i][2:0];
        end
        for (int j = 0; j < TB_DEPTH; j++) begin
            if (we && waddr == 8'(TB_BASE + j))
                bank_d.tb[j] = wdata;
            if (raddr == 8'(TB_BASE + j))
                rdata = bank_q.tb[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

endmodule

// File: rtl/rtc_wp_guard.sv
module rtc_wp_guard (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_we,
    input  logic [7:0] st_data,
    input  logic       relock,
    input  logic       tb_done,
    output logic       wel,
    output logic       rwel,
    output logic       rtcf
);

    typedef struct packed {
        logic wel;
        logic rwel;
        logic rtcf;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (st_we) begin
            case (st_data)
                8'h00: begin g_d.wel = 1'b0; g_d.rwel = 1'b0; end
                8'h02: begin g_d.wel = 1'b1; g_d.rwel = 1'b0; end
                8'h06: if (g_q.wel) g_d.rwel = 1'b1;
                default: ;
            endcase
        end
        if (relock)  g_d.rwel = 1'b0;
        if (tb_done) g_d.rtcf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{wel: 1'b0, rwel: 1'b0, rtcf: 1'b1};
        else        g_q <= g_d;
    end

    assign wel  = g_q.wel;
    assign rwel = g_q.rwel;
    assign rtcf = g_q.rtcf;

endmodule

// File: rtl/rtc_wp_busy.sv
module rtc_wp_busy #(
    parameter int CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/rtc_wp_ctrl.sv
module rtc_wp_ctrl
    import rtc_wp_pkg::*;
#(
    parameter int BUSY_CYCLES = 2000000,
    parameter int NV_DEPTH    = 20,
    parameter int TB_DEPTH    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_vld,
    input  logic [7:0]        addr_hi,
    input  logic [7:0]        addr_lo,
    input  logic              wr_vld,
    input  logic [7:0]        wr_byte,
    input  logic              rd_vld,
    input  logic              stop,
    input  logic              alarm_in,
    output logic [7:0]        rd_data,
    output logic              rd_ack,
    output logic              busy,
    output logic              clk_fail,
    output logic signed [5:0] trim_ppm
);

    localparam int         TB_BASE_I = int'(NV_LIMIT);
    localparam logic [7:0] TB_END    = 8'(TB_BASE_I + TB_DEPTH);

    typedef struct packed {
        logic [7:0] ptr;
        logic       hi_ok;
        logic       nv_pend;
        logic       tb_pend;
        logic       rd_ack;
        logic [7:0] rd_data;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic       bank_we, st_we, busy_start, relock, tb_done;
    logic       wel, rwel, rtcf;
    logic [7:0] bank_rdata, status_val;
    logic [2:0] dtrim_bits;

    assign status_val = {2'b00, alarm_in, 2'b00, rwel, wel, rtcf};

    always_comb begin
        st_d        = st_q;
        st_d.rd_ack = 1'b0;
        bank_we     = 1'b0;
        st_we       = 1'b0;
        busy_start  = 1'b0;
        relock      = 1'b0;
        tb_done     = 1'b0;
        if (hdr_vld) begin
            st_d.ptr   = addr_lo;
            st_d.hi_ok = (addr_hi == 8'h00);
        end else begin
            if (wr_vld) begin
                st_d.ptr = st_q.ptr + 8'd1;
                if (st_q.hi_ok && !busy) begin
                    if (st_q.ptr == STATUS_ADDR) begin
                        st_we = 1'b1;
                    end else if (wel && rwel) begin
                        bank_we = 1'b1;
                        if (st_q.ptr < NV_LIMIT)
                            st_d.nv_pend = 1'b1;
                        else if (st_q.ptr < TB_END)
                            st_d.tb_pend = 1'b1;
                    end
                end
            end else if (rd_vld) begin
                st_d.ptr    = st_q.ptr + 8'd1;
                st_d.rd_ack = 1'b1;
                if (!st_q.hi_ok)
                    st_d.rd_data = 8'h00;
                else if (st_q.ptr == STATUS_ADDR)
                    st_d.rd_data = status_val;
                else
                    st_d.rd_data = bank_rdata;
            end
            if (stop) begin
                busy_start   = st_q.nv_pend;
                relock       = st_q.nv_pend;
                tb_done      = st_q.tb_pend;
                st_d.nv_pend = 1'b0;
                st_d.tb_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rtc_wp_regbank #(
        .NV_DEPTH (NV_DEPTH),
        .TB_BASE  (TB_BASE_I),
        .TB_DEPTH (TB_DEPTH)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bank_we),
        .waddr      (st_q.ptr),
        .wdata      (wr_byte),
        .raddr      (st_q.ptr),
        .rdata      (bank_rdata),
        .dtrim_bits (dtrim_bits)
    );

    rtc_wp_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_we   (st_we),
        .st_data (wr_byte),
        .relock  (relock),
        .tb_done (tb_done),
        .wel     (wel),
        .rwel    (rwel),
        .rtcf    (rtcf)
    );

    rtc_wp_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (busy_start),
        .busy  (busy)
    );

    assign rd_data  = st_q.rd_data;
    assign rd_ack   = st_q.rd_ack;
    assign clk_fail = rtcf;
    assign trim_ppm = trim_decode(dtrim_bits);

endmodule

// File: rtl/rtc_wp_ctrl_chk.sv
module rtc_wp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hdr_vld,
    input logic       wr_vld,
    input logic       rd_vld,
    input logic       busy,
    input logic       wel,
    input logic       rwel,
    input logic       rd_ack,
    input logic [7:0] rd_data,
    input logic [7:0] ptr,
    input logic       hi_ok
);

    // R2: the register enable never stands without the latch
    a_r2_rwel_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel);

    // R5: the busy window opens with the register enable dropped
    a_r5_busy_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rwel);

    // R6: writes while busy leave the enables untouched
    a_r6_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_vld && !hdr_vld) |=> ($stable(wel) && $stable(rwel)));

    // R8: a read strobe is answered on the next cycle
    a_r8_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && !hdr_vld && !wr_vld) |=> rd_ack);

    // R7: register 0x10 is fully reserved
    a_r7_reg10_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && $past(ptr) == 8'h11 && $past(hi_ok) && $past(rd_vld) &&
         $past(ptr, 2) == 8'h10 && $past(rd_vld, 2) && !$past(hdr_vld, 2))
        |-> $past(rd_data) == 8'h00);

    // R12: a nonzero high address byte reads as zero
    a_r12_bad_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !$past(hi_ok)) |-> rd_data == 8'h00);

endmodule

bind rtc_wp_ctrl rtc_wp_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hdr_vld (hdr_vld),
    .wr_vld  (wr_vld),
    .rd_vld  (rd_vld),
    .busy    (busy),
    .wel     (wel),
    .rwel    (rwel),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .ptr     (st_q.ptr),
    .hi_ok   (st_q.hi_ok)
);

// File: tb/rtc_wp_ctrl_test.sv
`timescale 1ns/1ps
module rtc_wp_ctrl_test;

    localparam int BUSY = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hdr_vld = 1'b0, wr_vld = 1'b0, rd_vld = 1'b0, stop = 1'b0;
    logic              alarm_in = 1'b0;
    logic [7:0]        addr_hi = 8'h00, addr_lo = 8'h00, wr_byte = 8'h00;
    logic [7:0]        rd_data;
    logic              rd_ack, busy, clk_fail;
    logic signed [5:0] trim_ppm;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    rtc_wp_ctrl #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .addr_hi(addr_hi),
        .addr_lo(addr_lo), .wr_vld(wr_vld), .wr_byte(wr_byte), .rd_vld(rd_vld),
        .stop(stop), .alarm_in(alarm_in), .rd_data(rd_data), .rd_ack(rd_ack),
        .busy(busy), .clk_fail(clk_fail), .trim_ppm(trim_ppm)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hdr(input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk); hdr_vld = 1'b1; addr_hi = hi; addr_lo = lo;
        @(negedge clk); hdr_vld = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); wr_vld = 1'b1; wr_byte = b;
        @(negedge clk); wr_vld = 1'b0;
    endtask

    task automatic rd(input logic [7:0] exp, input string tag);
        @(negedge clk); rd_vld = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_vld = 1'b0;
    endtask

    task automatic stp();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    // Monitor: compare each acknowledged read with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rd_ack) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected read ack", int'(rd_data), -1);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data === e, t, int'(rd_data), int'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_fail === 1'b1, "R1 clk_fail at reset", int'(clk_fail), 1);
        chk(busy === 1'b0, "R1 busy at reset", int'(busy), 0);
        hdr(8'h00, 8'h3F); rd(8'h01, "R1 status after reset");
        hdr(8'h00, 8'h31); rd(8'h00, "R1 stored reg reset");

        // R3: locked write
        hdr(8'h00, 8'h31); wr(8'h45); stp();
        hdr(8'h00, 8'h31); rd(8'h00, "R3 locked write ignored");

        // R2: unlock order
        hdr(8'h00, 8'h3F); wr(8'h06);
        hdr(8'h00, 8'h3F); rd(8'h01, "R2 0x06 before latch ignored");
        hdr(8'h00, 8'h3F); wr(8'h02);
        hdr(8'h00, 8'h3F); rd(8'h03, "R2 0x02 sets latch");
        hdr(8'h00, 8'h3F); wr(8'h55);
        hdr(8'h00, 8'h3F); rd(8'h03, "R2 other value ignored");
        hdr(8'h00, 8'h3F); wr(8'h06);
        hdr(8'h00, 8'h3F); rd(8'h07, "R2 0x06 sets register enable");

        // R4/R9: time bank burst
        hdr(8'h00, 8'h30); wr(8'h12); wr(8'h34); wr(8'h56); stp();
        @(negedge clk);
        chk(clk_fail === 1'b0, "R9 clk_fail cleared", int'(clk_fail), 0);
        chk(busy === 1'b0, "R5 no busy after time write", int'(busy), 0);
        hdr(8'h00, 8'h30);
        rd(8'h12, "R4 burst byte 0"); rd(8'h34, "R4 burst byte 1"); rd(8'h56, "R4 burst byte 2");
        hdr(8'h00, 8'h3F); rd(8'h06, "R9 status bit0 cleared");

        // R12: nonzero high byte
        hdr(8'h01, 8'h31); wr(8'h99);
        hdr(8'h01, 8'h31); rd(8'h00, "R12 read with bad high byte");
        hdr(8'h00, 8'h31); rd(8'h34, "R12 write with bad high byte ignored");

        // R7/R5: nonvolatile burst of all ones
        hdr(8'h00, 8'h10); wr(8'hFF); wr(8'hFF); wr(8'hFF); wr(8'hFF); stp();
        @(negedge clk);
        chk(busy === 1'b1, "R5 busy after nonvolatile write", int'(busy), 1);
        hdr(8'h00, 8'h3F); rd(8'h02, "R5 register enable dropped");
        // R6: status writes during busy
        hdr(8'h00, 8'h3F); wr(8'h06);
        hdr(8'h00, 8'h3F); wr(8'h00);
        hdr(8'h00, 8'h3F); rd(8'h02, "R6 status write ignored while busy");
        hdr(8'h00, 8'h10);
        rd(8'h00, "R7 reg 0x10 reserved"); rd(8'hE7, "R7 reg 0x11 mask");
        rd(8'h3F, "R7 reg 0x12 mask");     rd(8'h07, "R7 reg 0x13 mask");
        hdr(8'h00, 8'h20); rd(8'h00, "R7 unimplemented 0x20");
        hdr(8'h00, 8'h38); rd(8'h00, "R7 unimplemented 0x38");
        hdr(8'h00, 8'h40); rd(8'h00, "R7 above status");
        chk(trim_ppm === -6'sd30, "R10 trim all bits", int'(trim_ppm), -30);
        repeat (BUSY + 5) @(negedge clk);
        chk(busy === 1'b0, "R5 busy ends", int'(busy), 0);

        // R10: positive trim after relock
        hdr(8'h00, 8'h3F); wr(8'h06);
        hdr(8'h00, 8'h13); wr(8'h01); stp();
        repeat (BUSY + 5) @(negedge clk);
        chk(trim_ppm === 6'sd20, "R10 trim +20", int'(trim_ppm), 20);
        hdr(8'h00, 8'h3F); wr(8'h06);
        hdr(8'h00, 8'h13); wr(8'h06); stp();
        repeat (BUSY + 5) @(negedge clk);
        chk(trim_ppm === -6'sd10, "R10 trim -10", int'(trim_ppm), -10);

        // R11 and R2 clear
        alarm_in = 1'b1;
        hdr(8'h00, 8'h3F); rd(8'h22, "R11 alarm bit");
        hdr(8'h00, 8'h3F); wr(8'h00);
        hdr(8'h00, 8'h3F); rd(8'h20, "R2 0x00 clears enables");
        alarm_in = 1'b0;
        hdr(8'h00, 8'h3F); rd(8'h00, "R11 alarm bit low");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all reads acknowledged", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule